// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Unit

This block sits beside the sequencer of an 8-bit processor core and decides, once per instruction, whether the core should divert to an interrupt handler. It watches five request inputs. One is a trap that cannot be masked. Three are restart requests ranked 7.5, 6.5 and 5.5, and each has its own mask bit. The last is a general request. Each input is edge-detected into a sticky pending latch, so a request pulse that arrives between instruction boundaries is kept.

When the core signals an instruction boundary, the unit picks the highest-ranked request that may be serviced. It then raises a one-cycle accept pulse together with the 16-bit handler address. The core treats that pulse as its cue to push the return address and to load the program counter. Only the request that was served leaves the pending set. A small mask register holds the three restart mask bits and a global enable bit. The core loads it from its accumulator with a set-mask operation and reads it back with a read-mask operation. Two strobes set and clear the global enable.

Top module: `irqv_unit`

## Requirements
- R1: After reset no accept pulse is produced, nothing is pending, and a read of the mask register returns 0x00.
- R2: A pending trap is accepted at a boundary even while the global enable is 0, and its vector is 0x0024.
- R3: Restart and general requests are accepted only while the global enable is 1. Among those that can be serviced, the ranking and vectors are: 7.5 → 0x003C, then 6.5 → 0x0034, then 5.5 → 0x002C, then general → 0x0038.
- R4: The 7.5, 6.5 and 5.5 requests are serviced only while their mask bits are set; these are bits 2, 1 and 0 of the mask register. A masked request stays pending and is served once its bit is set.
- R5: The global enable is bit 3 of the mask register. The enable strobe sets it and the disable strobe clears it.
- R6: A set-mask write copies bits 2..0 of the written byte into the mask bits only when bit 3 of that byte is 1. Otherwise the mask bits keep their value.
- R7: A read-mask strobe places the mask register, zero-extended, on rd_data in the cycle after the strobe.
- R8: Accepting a request clears only that request's pending latch. All other pending requests remain and are served at later boundaries.
- R9: At most one request is accepted per boundary. The accept output is a one-cycle pulse in the cycle after the boundary strobe, and no accept occurs without a boundary.
- R10: Accepting a restart or general request clears the global enable. Accepting the trap leaves the enable unchanged.
- R11: A request becomes pending on a rising edge of its input. A short pulse away from a boundary is kept, and an input held high yields exactly one request.
- R12: The trap outranks every other request, including enabled and unmasked ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Non-maskable trap request |
| rq75_in | input | 1 | Restart 7.5 request |
| rq65_in | input | 1 | Restart 6.5 request |
| rq55_in | input | 1 | Restart 5.5 request |
| gen_in | input | 1 | General request |
| boundary | input | 1 | Instruction boundary strobe from the core |
| en_stb | input | 1 | Set global enable |
| dis_stb | input | 1 | Clear global enable |
| mask_wr | input | 1 | Set-mask strobe |
| wr_data | input | 8 | Accumulator byte for set-mask |
| mask_rd | input | 1 | Read-mask strobe |
| rd_data | output | 8 | Mask register as read back |
| take | output | 1 | Accept pulse; the core pushes its return address |
| vec | output | 16 | Handler address, valid with take |

## Verification
A rising request edge at clock k makes the request pending after k. A boundary strobe sampled at clock k+1 or later then raises take and vec right after that clock. In the same way, rd_data and the mask bits update right after the clock that samples mask_rd, mask_wr or a strobe. The bench drives every input 1 ns after a rising edge. It checks register reads and missing accepts 1 ns after the next rising edge. A monitor compares each accept with the head of an expected-vector queue at the falling edge, half a cycle after it appears. Vectors left in the queue at the end, and accepts that no vector was queued for, both count as miscompares.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    // Source index equals rank: lower index wins.
    localparam int NSRC = 5;
    typedef enum logic [2:0] {
        SRC_TRAP = 3'd0,
        SRC_R75  = 3'd1,
        SRC_R65  = 3'd2,
        SRC_R55  = 3'd3,
        SRC_GEN  = 3'd4
    } src_e;

    // Mask register bit positions (also the byte layout of set-mask writes)
    localparam int MB_55  = 0;
    localparam int MB_65  = 1;
    localparam int MB_75  = 2;
    localparam int MB_IE  = 3;
    localparam int MB_MSE = 3;
    localparam int MASK_W = 4;
endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_d, prev_q;
    logic [N-1:0] pend_d, pend_q;

    // A new edge wins over a clear in the same cycle.
    always_comb begin
        prev_d = req;
        for (int i = 0; i < N; i++) begin
            pend_d[i] = (pend_q[i] & ~clr[i]) | (req[i] & ~prev_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] cand,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] above;

    assign above[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_rank
        assign grant[g]   = cand[g] & ~above[g];
        assign above[g+1] = above[g] | cand[g];
    end
    assign any = above[N];
endmodule

// File: rtl/irqv_unit.sv
module irqv_unit #(
    parameter int              DAT_W    = 8,
    parameter int              VEC_W    = 16,
    parameter logic [VEC_W-1:0] V_TRAP  = 16'h0024,
    parameter logic [VEC_W-1:0] V_R75   = 16'h003C,
    parameter logic [VEC_W-1:0] V_R65   = 16'h0034,
    parameter logic [VEC_W-1:0] V_R55   = 16'h002C,
    parameter logic [VEC_W-1:0] V_GEN   = 16'h0038
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_in,
    input  logic             rq75_in,
    input  logic             rq65_in,
    input  logic             rq55_in,
    input  logic             gen_in,
    input  logic             boundary,
    input  logic             en_stb,
    input  logic             dis_stb,
    input  logic             mask_wr,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             mask_rd,
    output logic [DAT_W-1:0] rd_data,
    output logic             take,
    output logic [VEC_W-1:0] vec
);
    import irqv_pkg::*;

    localparam int PAD_W = DAT_W - MASK_W;

    typedef struct packed {
        logic [MASK_W-1:0] imask;
        logic              take;
        logic [VEC_W-1:0]  vec;
        logic [DAT_W-1:0]  rdat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSRC-1:0]  req_v, pend, cand, grant, clr;
    logic             any;
    logic [VEC_W-1:0] vec_tab [NSRC];
    logic [VEC_W-1:0] sel_vec;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DAT_W-1:MASK_W];

    assign req_v[SRC_TRAP] = trap_in;
    assign req_v[SRC_R75]  = rq75_in;
    assign req_v[SRC_R65]  = rq65_in;
    assign req_v[SRC_R55]  = rq55_in;
    assign req_v[SRC_GEN]  = gen_in;

    assign vec_tab[SRC_TRAP] = V_TRAP;
    assign vec_tab[SRC_R75]  = V_R75;
    assign vec_tab[SRC_R65]  = V_R65;
    assign vec_tab[SRC_R55]  = V_R55;
    assign vec_tab[SRC_GEN]  = V_GEN;

    irqv_edge_latch #(.N(NSRC)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_v),
        .clr   (clr),
        .pend  (pend)
    );

    // Serviceable candidates, gated by enable and per-source masks
    assign cand[SRC_TRAP] = pend[SRC_TRAP];
    assign cand[SRC_R75]  = pend[SRC_R75] & ctl_q.imask[MB_IE] & ctl_q.imask[MB_75];
    assign cand[SRC_R65]  = pend[SRC_R65] & ctl_q.imask[MB_IE] & ctl_q.imask[MB_65];
    assign cand[SRC_R55]  = pend[SRC_R55] & ctl_q.imask[MB_IE] & ctl_q.imask[MB_55];
    assign cand[SRC_GEN]  = pend[SRC_GEN] & ctl_q.imask[MB_IE];

    irqv_prio_pick #(.N(NSRC)) u_pick (
        .cand  (cand),
        .grant (grant),
        .any   (any)
    );

    assign clr = (boundary && any) ? grant : '0;

    always_comb begin
        sel_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) sel_vec = sel_vec | vec_tab[i];
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.take = boundary && any;
        if (boundary && any) ctl_d.vec = sel_vec;
        if (mask_rd) ctl_d.rdat = {{PAD_W{1'b0}}, ctl_q.imask};
        if (mask_wr && wr_data[MB_MSE]) begin
            ctl_d.imask[MB_75] = wr_data[MB_75];
            ctl_d.imask[MB_65] = wr_data[MB_65];
            ctl_d.imask[MB_55] = wr_data[MB_55];
        end
        if (en_stb)  ctl_d.imask[MB_IE] = 1'b1;
        if (dis_stb) ctl_d.imask[MB_IE] = 1'b0;
        if (boundary && any && !grant[SRC_TRAP]) ctl_d.imask[MB_IE] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign take    = ctl_q.take;
    assign vec     = ctl_q.vec;
    assign rd_data = ctl_q.rdat;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int               DAT_W  = 8,
    parameter int               VEC_W  = 16,
    parameter logic [VEC_W-1:0] V_TRAP = 16'h0024,
    parameter logic [VEC_W-1:0] V_R75  = 16'h003C,
    parameter logic [VEC_W-1:0] V_R65  = 16'h0034,
    parameter logic [VEC_W-1:0] V_R55  = 16'h002C,
    parameter logic [VEC_W-1:0] V_GEN  = 16'h0038
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boundary,
    input logic             mask_wr,
    input logic             mse_bit,
    input logic             take,
    input logic [VEC_W-1:0] vec,
    input logic [3:0]       imask
);
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));                                               // R9
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vec == V_TRAP || vec == V_R75 || vec == V_R65 ||
                  vec == V_R55 || vec == V_GEN));                                // R3
    AST_MASKABLE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec != V_TRAP) |-> $past(imask[3]));                            // R3
    AST_MASKABLE_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec != V_TRAP) |-> !imask[3]);                                  // R10
    AST_R75_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec == V_R75) |-> $past(imask[2]));                             // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mask_wr && mse_bit) |-> $stable(imask[2:0]));                     // R6
endmodule

bind irqv_unit irqv_checker #(
    .DAT_W (DAT_W), .VEC_W (VEC_W), .V_TRAP (V_TRAP), .V_R75 (V_R75),
    .V_R65 (V_R65), .V_R55 (V_R55), .V_GEN (V_GEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .mask_wr  (mask_wr),
    .mse_bit  (wr_data[3]),
    .take     (take),
    .vec      (vec),
    .imask    (ctl_q.imask)
);

// File: tb/sim_irqv_unit.sv
`timescale 1ns/1ps
module sim_irqv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_in = 0, rq75_in = 0, rq65_in = 0, rq55_in = 0, gen_in = 0;
    logic        boundary = 0, en_stb = 0, dis_stb = 0, mask_wr = 0, mask_rd = 0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        take;
    logic [15:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    irqv_unit u0 (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rq75_in(rq75_in),
        .rq65_in(rq65_in), .rq55_in(rq55_in), .gen_in(gen_in),
        .boundary(boundary), .en_stb(en_stb), .dis_stb(dis_stb),
        .mask_wr(mask_wr), .wr_data(wr_data), .mask_rd(mask_rd),
        .rd_data(rd_data), .take(take), .vec(vec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every accept is compared with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && take) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected accept", int'(vec), 0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(vec == e, t, int'(vec), int'(e));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: trap_in = 1;
            1: rq75_in = 1;
            2: rq65_in = 1;
            3: rq55_in = 1;
            default: gen_in = 1;
        endcase
        tick();
        trap_in = 0; rq75_in = 0; rq65_in = 0; rq55_in = 0; gen_in = 0;
    endtask

    task automatic bnd_exp(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        boundary = 1;
        tick();
        boundary = 0;
    endtask

    task automatic bnd_none(input string tag);
        boundary = 1;
        tick();
        boundary = 0;
        chk(take == 1'b0, tag, int'(take), 0);
    endtask

    task automatic rd_exp(input logic [7:0] e, input string tag);
        mask_rd = 1;
        tick();
        mask_rd = 0;
        chk(rd_data == e, tag, int'(rd_data), int'(e));
    endtask

    task automatic wr_mask(input logic [7:0] d);
        mask_wr = 1; wr_data = d;
        tick();
        mask_wr = 0; wr_data = '0;
    endtask

    task automatic en();
        en_stb = 1; tick(); en_stb = 0;
    endtask

    task automatic dis();
        dis_stb = 1; tick(); dis_stb = 0;
    endtask

    task automatic finish_run();
        while (exp_q.size() > 0) begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(1'b0, t, 0, int'(e));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(take == 1'b0, "R1 take after reset", int'(take), 0);
        rd_exp(8'h00, "R1 mask after reset");
        bnd_none("R1 nothing pending");

        // R2 trap while disabled
        pulse(0);
        bnd_exp(16'h0024, "R2 trap vector with enable off");
        bnd_none("R8 trap cleared after service");

        // R3 general request needs enable; R5 enable bit; R10 enable dropped
        pulse(4);
        bnd_none("R3 general blocked while disabled");
        en();
        rd_exp(8'h08, "R5 enable strobe sets bit 3");
        bnd_exp(16'h0038, "R3 general vector");
        rd_exp(8'h00, "R10 enable cleared on accept");

        // R6 write without mask-set-enable, then with it; R7 read-back
        wr_mask(8'h07);
        rd_exp(8'h00, "R6 write ignored without bit 3");
        wr_mask(8'h0F);
        rd_exp(8'h07, "R7 read returns mask bits");
        en();
        rd_exp(8'h0F, "R7 read returns enable and mask");

        // R3 ranking with everything pending; R8 others stay pending
        pulse(3); pulse(2); pulse(1); pulse(4);
        bnd_exp(16'h003C, "R3 7.5 ranks first");
        bnd_none("R10 no nesting without new enable");
        en();
        bnd_exp(16'h0034, "R8 6.5 still pending");
        en();
        bnd_exp(16'h002C, "R8 5.5 still pending");
        en();
        bnd_exp(16'h0038, "R8 general still pending");

        // R4 per-source masks
        wr_mask(8'h0A);
        en();
        rd_exp(8'h0A, "R4 only 6.5 unmasked");
        pulse(1);
        bnd_none("R4 masked 7.5 not served");
        pulse(2);
        bnd_exp(16'h0034, "R4 unmasked 6.5 served");
        wr_mask(8'h0F);
        en();
        bnd_exp(16'h003C, "R4 7.5 served after unmask");

        // R12 trap outranks enabled restart; R10 trap keeps enable
        en();
        pulse(3);
        pulse(0);
        bnd_exp(16'h0024, "R12 trap outranks 5.5");
        rd_exp(8'h0F, "R10 trap keeps enable");
        bnd_exp(16'h002C, "R8 5.5 after trap");

        // R11 held level gives one request
        en();
        rq55_in = 1;
        repeat (3) tick();
        bnd_exp(16'h002C, "R11 level produces a request");
        en();
        bnd_none("R11 held level not re-requested");
        rq55_in = 0;
        tick();

        // R5 disable strobe; R6 ignored write keeps mask
        dis();
        wr_mask(8'h30);
        rd_exp(8'h07, "R5 disable clears bit 3, R6 mask kept");
        pulse(4);
        bnd_none("R5 general blocked after disable");
        en();
        bnd_exp(16'h0038, "R5 general served after enable");

        // R9 no accept without boundary; R11 short pulse kept
        pulse(0);
        for (int i = 0; i < 3; i++) begin
            chk(take == 1'b0, "R9 no accept without boundary", int'(take), 0);
            tick();
        end
        bnd_exp(16'h0024, "R11 short trap pulse kept");
        tick();
        chk(take == 1'b0, "R9 accept lasts one cycle", int'(take), 0);

        repeat (3) tick();
        done = 1;
        finish_run();
    end
endmodule